// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt sources, either hardware lines or bits set by software, and presents them to a processor on two outputs. The normal output is `irq_o` and the fast output is `fiq_o`. Each source has its own enable bit and its own steering bit, which picks the output the source drives. Software changes the enables and the software-trigger bits through separate write-one-to-set and write-one-to-clear registers. This lets a driver touch one source without a read-modify-write.

For the normal output, sixteen vector slots each name a source and hold a handler address. Slot number is priority, and the lowest number wins. When the processor reads the current-vector register, it gets the address of the best matching slot, or the default address if no slot matches. That read also marks the slot's priority level as in service, so that only lower-numbered slots can pre-empt it. Writing any value to the same register ends service of the level most recently taken. Repeated end-of-service writes with nothing in service are harmless, so a start-up sequence of read and write-back pairs leaves the controller idle.

The register interface is a single-cycle bus with 12-bit byte addresses. Read data is registered.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, all of the following are zero: the enable, steering and software-trigger registers, every status register, both interrupt outputs and every slot control word. The default vector address is also 0, so a current-vector read (offset 0x030) returns 0.
- R2: Reading offset 0x008 returns the raw status: the hardware source inputs OR the software-trigger bits.
- R3: A write to offset 0x010 sets every enable bit whose data bit is 1, and a write to 0x014 clears every enable bit whose data bit is 1. Data bits of 0 leave the enables unchanged. The enables read back at 0x010.
- R4: Offsets 0x018 (set) and 0x01C (clear) act on the software-trigger bits in the same way. The software-trigger bits read back at 0x018.
- R5: The steering register at 0x00C chooses the output for each source, with 1 meaning fast and 0 meaning normal. Normal status (read at 0x000) is raw & enable & ~steer. Fast status (read at 0x004) is raw & enable & steer. `irq_o` is the OR of the normal status and `fiq_o` is the OR of the fast status, and each output lags its status by one clock.
- R6: Slot n holds an address at 0x100+4n and a control word at 0x200+4n, with bit 5 as the slot enable and bits 4:0 as the source index. A current-vector read returns the address of the lowest-numbered enabled slot whose source is set in the normal status. Sources steered to fast never match.
- R7: If no slot is eligible, a current-vector read returns the default vector address, which is held at offset 0x034.
- R8: The in-service levels are slots 0 to 15, plus level 16 for the default. A current-vector read marks the level it returned. While levels are marked, only slots with a number below the lowest marked level are eligible. A write to 0x030 unmarks the lowest marked level.
- R9: A write to 0x030 with no level marked changes nothing, so after 19 such writes the controller behaves as freshly idle.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the identification parameter in bits 7:0, with the upper bits zero. Bits 19:12 of the assembled word are the vendor code.
- R11: The protection register (0x020) and the test-control register (0x300) each store and return bit 0. Write-only offsets (0x014, 0x01C) and unmapped offsets read 0.
- R12: Read data appears on the clock after the read access, and it is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Hardware interrupt source lines, level sensitive |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default widths: 32 sources and 16 slots. The identification word is overridden with a known value, so the byte assembly and the vendor field can be checked. These widths make the full 5-bit source index and all seventeen in-service levels reachable, including the default level. The pre-emption, the return to a lower level after end of service, and the drain by 19 write-backs can therefore all be exercised. The expected vectors come from a behavioural model of the slot table and the in-service levels that runs alongside the design.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [11:0] OFS_IRQ_STAT = 12'h000;
  localparam logic [11:0] OFS_FIQ_STAT = 12'h004;
  localparam logic [11:0] OFS_RAW      = 12'h008;
  localparam logic [11:0] OFS_STEER    = 12'h00C;
  localparam logic [11:0] OFS_EN_SET   = 12'h010;
  localparam logic [11:0] OFS_EN_CLR   = 12'h014;
  localparam logic [11:0] OFS_SW_SET   = 12'h018;
  localparam logic [11:0] OFS_SW_CLR   = 12'h01C;
  localparam logic [11:0] OFS_PROT     = 12'h020;
  localparam logic [11:0] OFS_CUR_VEC  = 12'h030;
  localparam logic [11:0] OFS_DEF_VEC  = 12'h034;
  localparam logic [11:0] OFS_TEST     = 12'h300;
  localparam logic [11:0] OFS_ID0      = 12'hFE0;
  localparam logic [11:0] OFS_ID1      = 12'hFE4;
  localparam logic [11:0] OFS_ID2      = 12'hFE8;
  localparam logic [11:0] OFS_ID3      = 12'hFEC;
  localparam logic [3:0]  PAGE_ADDR    = 4'h1;
  localparam logic [3:0]  PAGE_CTL     = 4'h2;
  localparam int          CTL_EN_POS   = 5;
endpackage

// File: rtl/ivc_src_regs.sv
module ivc_src_regs #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            sw_set_we,
  input  logic            sw_clr_we,
  input  logic            steer_we,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] steer_q,
  output logic [NSRC-1:0] sw_q,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      steer_q <= '0;
      sw_q    <= '0;
    end else begin
      if (en_set_we)      en_q <= en_q | wdata;
      else if (en_clr_we) en_q <= en_q & ~wdata;
      if (sw_set_we)      sw_q <= sw_q | wdata;
      else if (sw_clr_we) sw_q <= sw_q & ~wdata;
      if (steer_we)       steer_q <= wdata;
    end
  end

  assign raw      = src_i | sw_q;
  assign irq_stat = raw & en_q & ~steer_q;
  assign fiq_stat = raw & en_q & steer_q;

  assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
    en_set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
  assert_en_clr_R3: assert property (@(posedge clk) disable iff (rst)
    en_clr_we |=> ((en_q & $past(wdata)) == '0));
  assert_en_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (en_set_we || en_clr_we) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
  assert_sw_set_R4: assert property (@(posedge clk) disable iff (rst)
    sw_set_we |=> ((sw_q & $past(wdata)) == $past(wdata)));
  assert_sw_clr_R4: assert property (@(posedge clk) disable iff (rst)
    sw_clr_we |=> ((sw_q & $past(wdata)) == '0));
endmodule

// File: rtl/ivc_vec_unit.sv
module ivc_vec_unit #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int AW    = 32,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int SRC_W  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_stat,
  input  logic [SLOT_W-1:0] bus_idx,
  input  logic [AW-1:0]     wdata,
  input  logic              addr_we,
  input  logic              ctl_we,
  input  logic              def_we,
  input  logic              addr_rd,
  input  logic              vec_rd,
  input  logic              vec_pop,
  output logic [AW-1:0]     mem_q,
  output logic              vec_hit,
  output logic [AW-1:0]     def_q,
  output logic              ctl_en_rd,
  output logic [SRC_W-1:0]  ctl_src_rd
);
  import ivc_pkg::*;
  localparam int LVLS = NSLOT + 1;
  localparam int LW   = SLOT_W + 1;

  logic [AW-1:0]    addr_mem [NSLOT];
  logic [NSLOT-1:0] ctl_en;
  logic [SRC_W-1:0] ctl_src [NSLOT];
  logic [LVLS-1:0]  active_q;
  logic [LW-1:0]    lvl;
  logic [SLOT_W-1:0] pick;
  logic [SLOT_W-1:0] mem_idx;
  logic              mem_re;

  // Handler addresses: one write port, one registered read port.
  assign mem_re  = vec_rd | addr_rd;
  assign mem_idx = (vec_rd && vec_hit) ? pick : bus_idx;
  always_ff @(posedge clk) begin
    if (addr_we) addr_mem[bus_idx] <= wdata;
    if (mem_re)  mem_q <= addr_mem[mem_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= '0;
      def_q  <= '0;
      for (int i = 0; i < NSLOT; i++) ctl_src[i] <= '0;
    end else begin
      if (ctl_we) begin
        ctl_en[bus_idx]  <= wdata[CTL_EN_POS];
        ctl_src[bus_idx] <= wdata[SRC_W-1:0];
      end
      if (def_we) def_q <= wdata;
    end
  end

  assign ctl_en_rd  = ctl_en[bus_idx];
  assign ctl_src_rd = ctl_src[bus_idx];

  // Lowest marked level bounds the eligible slots; lowest slot wins.
  always_comb begin
    lvl = LW'(LVLS);
    for (int i = LVLS - 1; i >= 0; i--)
      if (active_q[i]) lvl = LW'(i);
    vec_hit = 1'b0;
    pick    = '0;
    for (int n = NSLOT - 1; n >= 0; n--)
      if ((LW'(n) < lvl) && ctl_en[n] && irq_stat[ctl_src[n]]) begin
        vec_hit = 1'b1;
        pick    = SLOT_W'(n);
      end
  end

  always_ff @(posedge clk) begin
    if (rst)
      active_q <= '0;
    else if (vec_rd)
      active_q <= active_q | (vec_hit ? (LVLS'(1) << pick) : (LVLS'(1) << NSLOT));
    else if (vec_pop)
      active_q <= active_q & (active_q - LVLS'(1));
  end

  assert_push_one_R8: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> ($countones(active_q ^ $past(active_q)) <= 1));
  assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (rst)
    (vec_pop && active_q != '0) |=> ($countones(active_q) == $countones($past(active_q)) - 1));
  assert_pop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (vec_pop && active_q == '0) |=> (active_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter logic [31:0] ID_WORD = 32'h0A5A_1C3D,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int SRC_W  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [11:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  import ivc_pkg::*;

  logic wr, rd, in_addr, in_ctl, vec_rd, vec_hit;
  logic [SLOT_W-1:0] bus_idx;
  logic [NSRC-1:0] raw, en_q, steer_q, sw_q, irq_stat, fiq_stat;
  logic [31:0] mem_q, def_q, misc_d, misc_q;
  logic ctl_en_rd, use_mem_q, prot_q, test_q;
  logic [SRC_W-1:0] ctl_src_rd;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign bus_idx = bus_addr[2 +: SLOT_W];
  assign in_addr = (bus_addr[11:8] == PAGE_ADDR) && ({1'b0, bus_addr[7:2]} < 7'(NSLOT))
                   && (bus_addr[1:0] == 2'b00);
  assign in_ctl  = (bus_addr[11:8] == PAGE_CTL) && ({1'b0, bus_addr[7:2]} < 7'(NSLOT))
                   && (bus_addr[1:0] == 2'b00);
  assign vec_rd  = rd && (bus_addr == OFS_CUR_VEC);

  ivc_src_regs #(.NSRC(NSRC)) i_src (
    .clk(clk), .rst(rst), .src_i(src_i),
    .en_set_we(wr && bus_addr == OFS_EN_SET),
    .en_clr_we(wr && bus_addr == OFS_EN_CLR),
    .sw_set_we(wr && bus_addr == OFS_SW_SET),
    .sw_clr_we(wr && bus_addr == OFS_SW_CLR),
    .steer_we(wr && bus_addr == OFS_STEER),
    .wdata(bus_wdata[NSRC-1:0]),
    .raw(raw), .en_q(en_q), .steer_q(steer_q), .sw_q(sw_q),
    .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  ivc_vec_unit #(.NSRC(NSRC), .NSLOT(NSLOT), .AW(32)) i_vec (
    .clk(clk), .rst(rst), .irq_stat(irq_stat), .bus_idx(bus_idx), .wdata(bus_wdata),
    .addr_we(wr && in_addr), .ctl_we(wr && in_ctl),
    .def_we(wr && bus_addr == OFS_DEF_VEC),
    .addr_rd(rd && in_addr), .vec_rd(vec_rd),
    .vec_pop(wr && bus_addr == OFS_CUR_VEC),
    .mem_q(mem_q), .vec_hit(vec_hit), .def_q(def_q),
    .ctl_en_rd(ctl_en_rd), .ctl_src_rd(ctl_src_rd)
  );

  always_comb begin
    misc_d = '0;
    if (in_ctl)
      misc_d = (32'(ctl_en_rd) << CTL_EN_POS) | 32'(ctl_src_rd);
    else
      case (bus_addr)
        OFS_IRQ_STAT: misc_d = 32'(irq_stat);
        OFS_FIQ_STAT: misc_d = 32'(fiq_stat);
        OFS_RAW:      misc_d = 32'(raw);
        OFS_STEER:    misc_d = 32'(steer_q);
        OFS_EN_SET:   misc_d = 32'(en_q);
        OFS_SW_SET:   misc_d = 32'(sw_q);
        OFS_PROT:     misc_d = 32'(prot_q);
        OFS_CUR_VEC:  misc_d = def_q;
        OFS_DEF_VEC:  misc_d = def_q;
        OFS_TEST:     misc_d = 32'(test_q);
        OFS_ID0:      misc_d = 32'(ID_WORD[7:0]);
        OFS_ID1:      misc_d = 32'(ID_WORD[15:8]);
        OFS_ID2:      misc_d = 32'(ID_WORD[23:16]);
        OFS_ID3:      misc_d = 32'(ID_WORD[31:24]);
        default:      misc_d = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem_q <= 1'b0;
      misc_q    <= '0;
      prot_q    <= 1'b0;
      test_q    <= 1'b0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (rd) begin
        use_mem_q <= (vec_rd && vec_hit) || in_addr;
        misc_q    <= misc_d;
      end
      if (wr && bus_addr == OFS_PROT) prot_q <= bus_wdata[0];
      if (wr && bus_addr == OFS_TEST) test_q <= bus_wdata[0];
      irq_o <= |irq_stat;
      fiq_o <= |fiq_stat;
    end
  end

  assign bus_rdata = use_mem_q ? mem_q : misc_q;

  assert_default_R7: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !vec_hit) |=> (bus_rdata == $past(def_q)));
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!rd && !$past(rd)) |=> $stable(bus_rdata));
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  localparam int NSRC = 32;
  localparam int NSLOT = 16;
  localparam logic [31:0] IDW = 32'h1357_9BDF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_en = '0, m_steer = '0, m_sw = '0, m_def = '0;
  logic [31:0] m_addr [NSLOT];
  logic [5:0]  m_ctl [NSLOT];
  logic [NSLOT:0] m_act = '0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .ID_WORD(IDW)) i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  // R12: data is registered at the edge after the access
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] got;
    rd(a, got);
    check(req, $sformatf("read %h", a), got, exp);
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  function automatic logic [31:0] f_irq(); return (src_i | m_sw) & m_en & ~m_steer; endfunction
  function automatic logic [31:0] f_fiq(); return (src_i | m_sw) & m_en & m_steer; endfunction

  task automatic en_set(input logic [31:0] v); wr(12'h010, v); m_en = m_en | v; endtask
  task automatic en_clr(input logic [31:0] v); wr(12'h014, v); m_en = m_en & ~v; endtask
  task automatic sw_set(input logic [31:0] v); wr(12'h018, v); m_sw = m_sw | v; endtask
  task automatic sw_clr(input logic [31:0] v); wr(12'h01C, v); m_sw = m_sw & ~v; endtask
  task automatic steer(input logic [31:0] v); wr(12'h00C, v); m_steer = v; endtask
  task automatic set_def(input logic [31:0] v); wr(12'h034, v); m_def = v; endtask

  task automatic set_slot(input int n, input logic [31:0] a, input logic en, input logic [4:0] s);
    wr(12'(12'h100 + 4 * n), a);
    wr(12'(12'h200 + 4 * n), {26'b0, en, s});
    m_addr[n] = a; m_ctl[n] = {en, s};
  endtask

  task automatic vec_read(input string req, output logic [31:0] got);
    int p, lvl;
    logic [31:0] st, exp;
    st = f_irq(); lvl = NSLOT + 1;
    for (int i = NSLOT; i >= 0; i--) if (m_act[i]) lvl = i;
    p = NSLOT;
    for (int n = NSLOT - 1; n >= 0; n--)
      if (n < lvl && m_ctl[n][5] && st[m_ctl[n][4:0]]) p = n;
    if (p < NSLOT) begin exp = m_addr[p]; m_act[p] = 1'b1; end
    else begin exp = m_def; m_act[NSLOT] = 1'b1; end
    rd(12'h030, got);
    check(req, "current vector", got, exp);
  endtask

  task automatic pop(); wr(12'h030, 32'h0); m_act = m_act & (m_act - 1'b1); endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1", "irq_o", 32'(irq_o), 0);
    check("R1", "fiq_o", 32'(fiq_o), 0);
    rd_chk("R1", 12'h000, 0); rd_chk("R1", 12'h004, 0); rd_chk("R1", 12'h008, 0);
    rd_chk("R1", 12'h00C, 0); rd_chk("R1", 12'h010, 0); rd_chk("R1", 12'h018, 0);
    rd_chk("R1", 12'h034, 0); rd_chk("R1", 12'h200, 0); rd_chk("R1", 12'h23C, 0);
    vec_read("R1", v);
    check("R1", "default after reset", v, 0);
    pop();
  endtask

  task automatic t_raw();
    src_i = 32'hA500_0011; settle();
    rd_chk("R2", 12'h008, 32'hA500_0011);
    sw_set(32'h0000_0300);
    rd_chk("R2", 12'h008, 32'hA500_0311);
    sw_clr(32'hFFFF_FFFF); src_i = '0; settle();
    rd_chk("R2", 12'h008, 0);
  endtask

  task automatic t_enable();
    en_set(32'h0000_00F0); rd_chk("R3", 12'h010, 32'h0000_00F0);
    en_set(32'h0F00_0000); rd_chk("R3", 12'h010, 32'h0F00_00F0);
    en_clr(32'h0000_0030); rd_chk("R3", 12'h010, 32'h0F00_00C0);
    en_set(32'h0); en_clr(32'h0); rd_chk("R3", 12'h010, 32'h0F00_00C0);
    en_clr(32'hFFFF_FFFF); rd_chk("R3", 12'h010, 0);
  endtask

  task automatic t_soft();
    sw_set(32'h8000_0001); rd_chk("R4", 12'h018, 32'h8000_0001);
    sw_clr(32'h0000_0001); rd_chk("R4", 12'h018, 32'h8000_0000);
    sw_set(32'h0); sw_clr(32'h0); rd_chk("R4", 12'h018, 32'h8000_0000);
    rd_chk("R4", 12'h008, 32'h8000_0000);
    sw_clr(32'hFFFF_FFFF); rd_chk("R4", 12'h018, 0);
  endtask

  task automatic t_steer();
    sw_set(32'h88); steer(32'h80); en_set(32'h88); settle();
    rd_chk("R5", 12'h000, 32'h08); rd_chk("R5", 12'h004, 32'h80);
    rd_chk("R5", 12'h00C, 32'h80);
    check("R5", "irq_o both", 32'(irq_o), 1); check("R5", "fiq_o both", 32'(fiq_o), 1);
    en_clr(32'h08); settle();
    check("R5", "irq_o masked", 32'(irq_o), 0); check("R5", "fiq_o kept", 32'(fiq_o), 1);
    rd_chk("R5", 12'h000, 0);
    sw_clr(32'hFFFF_FFFF); en_clr(32'hFFFF_FFFF); steer(0); settle();
    check("R5", "irq_o idle", 32'(irq_o), 0); check("R5", "fiq_o idle", 32'(fiq_o), 0);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    set_def(32'hDEF0_0000);
    set_slot(0, 32'h1000_0000, 1, 5'd1);
    set_slot(1, 32'h1111_1111, 0, 5'd4);
    set_slot(2, 32'h2000_0000, 1, 5'd4);
    set_slot(3, 32'h3000_0000, 1, 5'd6);
    set_slot(5, 32'h5000_0000, 1, 5'd6);
    en_set(32'h52);
    src_i = 32'h50; settle();
    vec_read("R6", v); check("R6", "slot 2 chosen, slot 1 disabled", v, 32'h2000_0000);
    src_i = 32'h52; settle();
    vec_read("R8", v); check("R8", "slot 0 pre-empts", v, 32'h1000_0000);
    vec_read("R8", v); check("R8", "nothing above level 0", v, 32'hDEF0_0000);
    pop();
    vec_read("R8", v);
    pop(); pop(); pop(); pop();
    steer(32'h10); src_i = 32'h50; settle();
    vec_read("R6", v); check("R6", "fast-steered source skipped", v, 32'h3000_0000);
    pop(); steer(0);
  endtask

  task automatic t_default();
    logic [31:0] v;
    src_i = '0; settle();
    vec_read("R7", v); check("R7", "no pending", v, 32'hDEF0_0000);
    pop();
    set_def(32'h0000_ABCC); rd_chk("R7", 12'h034, 32'h0000_ABCC);
    vec_read("R7", v); check("R7", "new default", v, 32'h0000_ABCC);
    pop();
  endtask

  task automatic t_drain();
    logic [31:0] v;
    src_i = 32'h52; settle();
    vec_read("R9", v); vec_read("R9", v); vec_read("R9", v);
    for (int i = 0; i < 19; i++) pop();
    check("R9", "model drained", 32'(m_act), 0);
    vec_read("R9", v); check("R9", "idle after drain", v, 32'h1000_0000);
    pop(); src_i = '0;
  endtask

  task automatic t_id();
    logic [31:0] b [4];
    logic [31:0] id;
    for (int i = 0; i < 4; i++) rd(12'(12'hFE0 + 4 * i), b[i]);
    for (int i = 0; i < 4; i++) check("R10", "upper bits zero", b[i] & 32'hFFFF_FF00, 0);
    id = {b[3][7:0], b[2][7:0], b[1][7:0], b[0][7:0]};
    check("R10", "assembled id", id, IDW);
    check("R10", "vendor field", 32'(id[19:12]), 32'h79);
  endtask

  task automatic t_misc();
    logic [31:0] a, b;
    wr(12'h020, 1); rd_chk("R11", 12'h020, 1);
    wr(12'h300, 1); rd_chk("R11", 12'h300, 1);
    wr(12'h300, 0); rd_chk("R11", 12'h300, 0);
    rd_chk("R6", 12'h104, 32'h1111_1111);
    rd_chk("R6", 12'h204, 32'h04);
    rd_chk("R6", 12'h208, 32'h24);
    rd_chk("R11", 12'h400, 0); rd_chk("R11", 12'h014, 0); rd_chk("R11", 12'h01C, 0);
    rd(12'h108, a); repeat (3) @(negedge clk); b = bus_rdata;
    check("R12", "read data held", b, a);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      src_i = $urandom;
      en_set($urandom); en_clr($urandom); steer($urandom);
      settle();
      rd_chk("R5", 12'h000, f_irq());
      rd_chk("R5", 12'h004, f_fiq());
      check("R5", "irq_o random", 32'(irq_o), 32'(|f_irq()));
      check("R5", "fiq_o random", 32'(fiq_o), 32'(|f_fiq()));
    end
    src_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) begin m_addr[i] = '0; m_ctl[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    settle();
    t_reset();
    t_raw();
    t_enable();
    t_soft();
    t_steer();
    t_vector();
    t_default();
    t_drain();
    t_id();
    t_misc();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule